// File: doc/BRIEF.md
# Multi-size shift and rotate unit

This unit applies one of eight shift or rotate operations to a 32-bit register value, working at byte, word or longword size. The operations are the arithmetic shifts (left and right), the logical shifts (left and right), the plain rotates (left and right) and the rotates through the carry flag (left and right). The distance is either one or two bit positions. The unit also produces the condition flags N, Z, V and C for the operand size that was selected. Register bits above that size are returned unchanged.

Operations enter on a valid/ready stream. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Its result is shown with `out_valid` from the next cycle. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so a full pipeline keeps one result per cycle. When `out_valid` is high and `out_ready` is low, the result and flags stay frozen and no new request is accepted.

Encodings:
- Size (`in_size`): 0 = byte (bits 7:0), 1 = word (bits 15:0), 2 or 3 = longword.
- Operation (`in_op`): 0 arithmetic left, 1 arithmetic right, 2 logical left, 3 logical right, 4 rotate left, 5 rotate right, 6 rotate left through carry, 7 rotate right through carry.
- Distance (`in_amt`): 0 = one position, 1 = two positions.

Top module: `shrot_unit`

## Requirements
- R1: At byte (size 0) and word (size 1), bits of the 32-bit result above the selected size equal the same bits of the operand. Size codes 2 and 3 both select longword.
- R2: Arithmetic left (op 0) and logical left (op 2) shift the selected-size value toward the MSB and fill the vacated low bits with zeros.
- R3: Arithmetic right (op 1) shifts toward the LSB and fills the vacated high bits with the sign bit of the selected size.
- R4: Logical right (op 3) shifts toward the LSB and fills the vacated high bits with zeros.
- R5: Rotate left (op 4) and rotate right (op 5) feed each bit that leaves one end of the selected-size value back in at the other end. The number of one bits in the result is unchanged.
- R6: Rotate through carry (op 6 left, op 7 right) treats the incoming carry as an extra bit beyond the MSB, so the rotation covers size+1 bits.
- R7: `in_amt` = 0 moves by exactly one position and `in_amt` = 1 moves by exactly two.
- R8: C is the last bit moved out of the selected-size value. For a two-position operation this is the second bit out.
- R9: N is the MSB of the result at the selected size. Z is 1 exactly when every result bit at that size is zero.
- R10: For arithmetic left, V is 1 when any bit that passes through the sign position differs from the original sign. For every other operation V is 0.
- R11: A request accepted on an edge shows its result with `out_valid` high after that edge. `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, the outputs hold steady.
- R12: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_operand | input | 32 | Register value to transform |
| in_size | input | 2 | Operand size code |
| in_op | input | 3 | Operation code |
| in_amt | input | 1 | Distance select: 0 = one, 1 = two |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Transformed register value |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
The bench builds the unit with the default datapath width of 32, which gives lanes of 8, 16 and 32 bits. At this width every combination of operation, size, distance and incoming carry can be swept against an independent reference model, using several random operands for each combination. Lanes this narrow also make it practical to aim directed operands at the sign-change cases of V, at carries shifted out of the top of a byte, and at preservation of the upper bits of the register. A stalled consumer is exercised to show that the result is held and that a queued request waits.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_ASL = 3'd0,
    OP_ASR = 3'd1,
    OP_LSL = 3'd2,
    OP_LSR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } shrot_op_e;

  localparam int NUM_LANES = 3;
endpackage

// File: rtl/shrot_step.sv
module shrot_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [2:0]   op,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);
  import shrot_pkg::*;

  always_comb begin
    y    = x;
    cout = 1'b0;
    unique case (shrot_op_e'(op))
      OP_ASL, OP_LSL: begin y = {x[W-2:0], 1'b0};   cout = x[W-1]; end
      OP_ASR:         begin y = {x[W-1], x[W-1:1]}; cout = x[0];   end
      OP_LSR:         begin y = {1'b0, x[W-1:1]};   cout = x[0];   end
      OP_ROL:         begin y = {x[W-2:0], x[W-1]}; cout = x[W-1]; end
      OP_ROR:         begin y = {x[0], x[W-1:1]};   cout = x[0];   end
      OP_RCL:         begin y = {x[W-2:0], cin};    cout = x[W-1]; end
      OP_RCR:         begin y = {cin, x[W-1:1]};    cout = x[0];   end
      default:        begin y = x;                  cout = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [2:0]   op,
  input  logic         amt,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         c,
  output logic         v
);
  import shrot_pkg::*;

  logic [W-1:0] y1, y2;
  logic         c1, c2;

  shrot_step #(.W(W)) u_first (.x(x),  .op(op), .cin(cin), .y(y1), .cout(c1));
  shrot_step #(.W(W)) u_second(.x(y1), .op(op), .cin(c1),  .y(y2), .cout(c2));

  always_comb begin
    y = amt ? y2 : y1;
    c = amt ? c2 : c1;
    v = (shrot_op_e'(op) == OP_ASL) &&
        ((y1[W-1] ^ x[W-1]) || (amt && (y2[W-1] ^ y1[W-1])));
  end

  always_comb begin
    // R5
    if (shrot_op_e'(op) == OP_ROL || shrot_op_e'(op) == OP_ROR)
      rot_pop_chk: assert ($countones(y) == $countones(x));
    // R6
    if (shrot_op_e'(op) == OP_RCL || shrot_op_e'(op) == OP_RCR)
      rotc_pop_chk: assert ($countones({c, y}) == $countones({cin, x}));
  end
endmodule

// File: rtl/shrot_stage.sv
module shrot_stage #(
  parameter int PW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          full_q;
  logic [PW-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  // R11
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_ready) |=> (full_q && $stable(data_q)));
  // R11
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> full_q);
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_operand,
  input  logic [1:0]    in_size,
  input  logic [2:0]    in_op,
  input  logic          in_amt,
  input  logic          in_carry,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_n,
  output logic          out_z,
  output logic          out_v,
  output logic          out_c
);
  import shrot_pkg::*;

  localparam int PW = DW + 4;

  logic [DW-1:0] lane_res [NUM_LANES];
  logic          lane_n   [NUM_LANES];
  logic          lane_z   [NUM_LANES];
  logic          lane_v   [NUM_LANES];
  logic          lane_c   [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = DW >> (NUM_LANES - 1 - g);
    localparam logic [DW-1:0] LMASK = {DW{1'b1}} >> (DW - LW);
    logic [LW-1:0] ly;
    logic          lc, lv;

    shrot_lane #(.W(LW)) u_lane (
      .x(in_operand[LW-1:0]), .op(in_op), .amt(in_amt), .cin(in_carry),
      .y(ly), .c(lc), .v(lv)
    );

    always_comb begin
      lane_res[g] = (in_operand & ~LMASK) | DW'(ly);
      lane_n[g]   = ly[LW-1];
      lane_z[g]   = ~|ly;
      lane_v[g]   = lv;
      lane_c[g]   = lc;
    end

    always_comb begin
      // R1
      if (LW < DW)
        upper_pass_chk: assert ((lane_res[g] & ~LMASK) == (in_operand & ~LMASK));
    end
  end

  logic [1:0]    sel;
  logic [PW-1:0] next_pl, held_pl;

  always_comb begin
    sel     = (in_size == 2'd0) ? 2'd0 : (in_size == 2'd1) ? 2'd1 : 2'd2;
    next_pl = {lane_res[sel], lane_n[sel], lane_z[sel], lane_v[sel], lane_c[sel]};
  end

  always_comb begin
    // R10
    if (shrot_op_e'(in_op) != OP_ASL)
      v_clear_chk: assert (!next_pl[1]);
  end

  shrot_stage #(.PW(PW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(next_pl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(held_pl)
  );

  assign {out_result, out_n, out_z, out_v, out_c} = held_pl;

  // R12
  reset_empty_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

// File: tb/shrot_unit_bench.sv
`timescale 1ns/1ps
module shrot_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_amt = 1'b0, in_carry = 1'b0, out_ready = 1'b1;
  logic [31:0] in_operand = '0;
  logic [1:0]  in_size = '0;
  logic [2:0]  in_op = '0;
  logic        in_ready, out_valid, out_n, out_z, out_v, out_c;
  logic [31:0] out_result;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  shrot_unit u_shrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_size(in_size), .in_op(in_op), .in_amt(in_amt),
    .in_carry(in_carry), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_model(input logic [31:0] x, input logic [2:0] op, input logic [1:0] sz,
                           input logic amt, input logic cin, output logic [31:0] r,
                           output logic n, output logic z, output logic v, output logic c);
    int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    int k = amt ? 2 : 1;
    logic [63:0] m  = (64'd1 << w) - 1;
    logic [63:0] m1 = (64'd1 << (w + 1)) - 1;
    logic [63:0] xv = {32'd0, x} & m;
    logic [63:0] e  = xv | ({63'd0, cin} << w);
    logic [63:0] y, re;
    v = 1'b0;
    case (op)
      3'd0, 3'd2: begin
        y = xv << k; c = xv[w-k];
        if (op == 3'd0)
          v = (k == 1) ? (xv[w-1] ^ xv[w-2])
                       : !((xv[w-1] == xv[w-2]) && (xv[w-2] == xv[w-3]));
      end
      3'd1: begin
        y = xv >> k; c = xv[k-1];
        for (int i = w - k; i < w; i++) y[i] = xv[w-1];
      end
      3'd3: begin y = xv >> k; c = xv[k-1]; end
      3'd4: begin y = ((xv << k) | (xv >> (w - k))) & m; c = y[0]; end
      3'd5: begin y = ((xv >> k) | (xv << (w - k))) & m; c = y[w-1]; end
      3'd6: begin re = ((e << k) | (e >> (w + 1 - k))) & m1; y = re; c = re[w]; end
      default: begin re = ((e >> k) | (e << (w + 1 - k))) & m1; y = re; c = re[w]; end
    endcase
    y = y & m;
    r = (x & ~m[31:0]) | y[31:0];
    n = y[w-1];
    z = (y == 0);
  endtask

  task automatic send(input logic [31:0] x, input logic [2:0] op, input logic [1:0] sz,
                      input logic amt, input logic cin);
    @(negedge clk);
    in_operand = x; in_op = op; in_size = sz; in_amt = amt; in_carry = cin;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_and_compare(input logic [31:0] x, input logic [2:0] op,
                                  input logic [1:0] sz, input logic amt, input logic cin);
    logic [31:0] r; logic n, z, v, c;
    string dtag;
    ref_model(x, op, sz, amt, cin, r, n, z, v, c);
    send(x, op, sz, amt, cin);
    case (op)
      3'd0, 3'd2: dtag = "R2 data";
      3'd1:       dtag = "R3 data";
      3'd3:       dtag = "R4 data";
      3'd4, 3'd5: dtag = "R5 data";
      default:    dtag = "R6 data";
    endcase
    chk("R11 out_valid", {31'd0, out_valid}, 32'd1);
    chk(dtag, out_result, r);
    chk("R8 carry", {31'd0, out_c}, {31'd0, c});
    chk("R9 n/z", {30'd0, out_n, out_z}, {30'd0, n, z});
    chk("R10 overflow", {31'd0, out_v}, {31'd0, v});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R12 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < 2; a++)
          for (int ci = 0; ci < 2; ci++)
            for (int t = 0; t < 3; t++)
              send_and_compare($urandom, 3'(op), 2'(sz), 1'(a), 1'(ci));
  endtask

  task automatic t_distance;
    send(32'h0000_0081, 3'd2, 2'd0, 1'b0, 1'b0);
    chk("R7 one position", out_result, 32'h0000_0002);
    send(32'h0000_0081, 3'd2, 2'd0, 1'b1, 1'b0);
    chk("R7 two positions", out_result, 32'h0000_0004);
  endtask

  task automatic t_corners;
    send(32'hAABB_CC01, 3'd4, 2'd0, 1'b1, 1'b0);
    chk("R1 upper bits kept at byte", out_result, 32'hAABB_CC04);
    send(32'h1234_8001, 3'd5, 2'd1, 1'b0, 1'b0);
    chk("R1 upper bits kept at word", out_result, 32'h1234_C000);
    send(32'h0000_0080, 3'd1, 2'd0, 1'b1, 1'b0);
    chk("R3 sign fill", out_result, 32'h0000_00E0);
    send(32'h0000_0080, 3'd6, 2'd0, 1'b1, 1'b0);
    chk("R6 through carry data", out_result, 32'h0000_0001);
    chk("R6 through carry C", {31'd0, out_c}, 32'd0);
    send(32'h0000_0040, 3'd0, 2'd0, 1'b0, 1'b0);
    chk("R10 V sign change", {31'd0, out_v}, 32'd1);
    send(32'h0000_00C0, 3'd0, 2'd0, 1'b0, 1'b0);
    chk("R10 V no change", {31'd0, out_v}, 32'd0);
    send(32'h0000_00C0, 3'd0, 2'd0, 1'b1, 1'b0);
    chk("R10 V second bit", {31'd0, out_v}, 32'd1);
    send(32'h0000_0001, 3'd3, 2'd2, 1'b0, 1'b0);
    chk("R9 zero flag", {30'd0, out_z, out_n}, 32'd2);
    chk("R8 last bit out", {31'd0, out_c}, 32'd1);
    send(32'h0000_0002, 3'd3, 2'd3, 1'b1, 1'b0);
    chk("R8 second bit out", {31'd0, out_c}, 32'd1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_operand = 32'h0000_0001; in_op = 3'd2; in_size = 2'd2; in_amt = 1'b0;
    in_carry = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R11 first result shown", out_result, 32'h0000_0002);
    chk("R11 not ready when full", {31'd0, in_ready}, 32'd0);
    in_operand = 32'h0000_0010;
    @(negedge clk);
    chk("R11 held under stall", out_result, 32'h0000_0002);
    chk("R11 still valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    #0;
    chk("R11 ready when drained", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 queued request follows", out_result, 32'h0000_0020);
    @(negedge clk);
    chk("R11 empty after drain", {31'd0, out_valid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_distance();
    t_corners();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule